// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter with Synchronous Restart

This block turns the 1-bit output stream of a sigma-delta modulator into signed multi-bit samples. It runs on a fast system clock and watches the modulator clock as a plain input. The modulator clock is brought into the system domain through a synchroniser, and each rising edge becomes a one-cycle sampling tick. On every tick the data bit is mapped to +1 or -1 and fed through three cascaded integrators. After every OSR ticks the last integrator value passes through three cascaded comb (difference) stages. The comb result is registered as the output word, with no truncation.

A timer-driven pulse on `filt_rst_in` restarts the filter. This lines up the decimation phase with an external control period. The pulse is captured in the system domain and takes effect at the next modulator tick. That tick clears all integrator and comb state and the phase counter, and its bit is thrown away. Because the first words after a restart are built from partial history, `dvalid` is held low until three output periods plus five modulator ticks have gone by. Driving `en` low has the same effect as a continuous restart.

Top module: `sinc3_decim`

## Requirements
- R1: With every input bit equal to 1 after a restart, every word flagged by `dvalid` equals +OSR^3 (+2097152 for OSR=128, +512 for OSR=8).
- R2: With every input bit equal to 0 after a restart, every flagged word equals -OSR^3.
- R3: Input bit 1 counts as +1 and bit 0 as -1. Number the bits accepted since the last restart x(1), x(2), and so on, with x(k)=0 for k<1. Let h be the three-fold self-convolution of a length-OSR all-ones window, which has length 3·OSR-2. The word for sample n is then y(n) = Σ_j h[j]·x(n-2-j), in two's complement of width 3·log2(OSR)+2.
- R4: A word is produced at each sample count n that is a multiple of OSR, counted from the last restart, and at no other count.
- R5: After a restart, `dvalid` fires only for words whose sample count n is at least 3·OSR+5. The first flagged word is therefore the fourth.
- R6: A one-cycle `filt_rst_in` pulse takes effect at the next modulator rising edge. That edge's bit is discarded, and the bit on the following edge is x(1).
- R7: A restart pulse that arrives while `dvalid` is still being held back starts the settling count again from zero.
- R8: `dvalid` is high for exactly one system clock per produced word and is never high on two cycles in a row.
- R9: While `en` is low, `dvalid` stays low. The first modulator edge after `en` returns high carries x(1).
- R10: During and right after system reset, `dvalid` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times faster than the modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable; low holds the filter cleared |
| mclk_in | input | 1 | Modulator bit clock, sampled in the system domain |
| mdat_in | input | 1 | Modulator data bit, valid at the rising edge of `mclk_in` |
| filt_rst_in | input | 1 | One-cycle restart request from a PWM timer |
| dout | output | DW | Signed decimated word |
| dvalid | output | 1 | One-cycle strobe marking a settled word on `dout` |

## Verification
The hardest case to reach is a restart that lands inside the settling window. Producing it from the ports requires a second pulse after fewer than 3·OSR+5 bits. The bench therefore restarts after 20 bits with OSR=8, then checks that exactly the words from sample counts 32 and 40 of the second run are flagged. For general bit patterns, the output must match a convolution with the sinc3 kernel. The bench builds that kernel arithmetically and sweeps alternating, dense, sparse and pseudo-random streams, each after its own restart.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER      = 3;
  localparam int EXTRA_CLKS = 5;

  function automatic int settle_ticks(input int osr);
    return ORDER * osr + EXTRA_CLKS;
  endfunction
endpackage

// File: rtl/sinc3_edge_sync.sv
module sinc3_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_in,
  input  logic mdat_in,
  output logic tick,
  output logic bit_val
);
  logic [SYNC:0]   ck_q;
  logic [SYNC-1:0] dt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[SYNC-1:0], mclk_in};
      dt_q <= {dt_q[SYNC-2:0], mdat_in};
    end
  end

  // rising edge of the synchronised modulator clock, data aligned to it
  assign tick    = ck_q[SYNC-1] & ~ck_q[SYNC];
  assign bit_val = dt_q[SYNC-1];
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int DW     = 23,
  parameter int STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic                 bit_val,
  output logic signed [DW-1:0] last
);
  logic signed [DW-1:0] acc  [STAGES];
  logic signed [DW-1:0] feed [STAGES];

  // bit 1 -> +1, bit 0 -> -1 in two's complement
  assign feed[0] = {{(DW-1){~bit_val}}, 1'b1};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_link
      assign feed[g] = acc[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr)
        acc[g] <= '0;
      else if (step)
        acc[g] <= acc[g] + feed[g];
    end
  end

  assign last = acc[STAGES-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int DW     = 23,
  parameter int STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 fire,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  logic signed [DW-1:0] dly  [STAGES];
  logic signed [DW-1:0] diff [STAGES+1];

  assign diff[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly[g];
    always_ff @(posedge clk) begin
      if (rst || clr)
        dly[g] <= '0;
      else if (fire)
        dly[g] <= diff[g];
    end
  end

  assign dout = diff[STAGES];
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int OSR  = 128,
  parameter int DW   = sinc3_pkg::ORDER * $clog2(OSR) + 2,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 mclk_in,
  input  logic                 mdat_in,
  input  logic                 filt_rst_in,
  output logic signed [DW-1:0] dout,
  output logic                 dvalid
);
  import sinc3_pkg::*;

  localparam int SETTLE = settle_ticks(OSR);
  localparam int PH_W   = $clog2(OSR);
  localparam int BL_W   = $clog2(SETTLE + 1);

  logic                 tick;
  logic                 bit_val;
  logic                 rst_pend;
  logic                 clr_now;
  logic                 step;
  logic [PH_W-1:0]      phase;
  logic [BL_W-1:0]      blank;
  logic                 dec_q;
  logic signed [DW-1:0] integ_out;
  logic signed [DW-1:0] comb_out;

  sinc3_edge_sync #(.SYNC(SYNC)) sync_i (
    .clk(clk), .rst(rst), .mclk_in(mclk_in), .mdat_in(mdat_in),
    .tick(tick), .bit_val(bit_val)
  );

  // restart request waits for the next modulator edge
  always_ff @(posedge clk) begin
    if (rst)
      rst_pend <= 1'b0;
    else if (filt_rst_in)
      rst_pend <= 1'b1;
    else if (tick)
      rst_pend <= 1'b0;
  end

  assign clr_now = tick & (rst_pend | ~en);
  assign step    = tick & ~clr_now;

  always_ff @(posedge clk) begin
    if (rst || clr_now) begin
      phase <= '0;
      blank <= '0;
    end else if (step) begin
      phase <= (phase == PH_W'(OSR - 1)) ? '0 : phase + 1'b1;
      if (blank < BL_W'(SETTLE))
        blank <= blank + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      dec_q <= 1'b0;
    else
      dec_q <= step && (phase == PH_W'(OSR - 1));
  end

  sinc3_integ #(.DW(DW), .STAGES(ORDER)) integ_i (
    .clk(clk), .rst(rst), .clr(clr_now), .step(step),
    .bit_val(bit_val), .last(integ_out)
  );

  sinc3_comb #(.DW(DW), .STAGES(ORDER)) comb_i (
    .clk(clk), .rst(rst), .clr(clr_now), .fire(dec_q),
    .din(integ_out), .dout(comb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= dec_q && en && (blank >= BL_W'(SETTLE));
      if (dec_q)
        dout <= comb_out;
    end
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int OSR = 128,
  parameter int DW  = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 tick,
  input logic                 clr_now,
  input logic                 dvalid,
  input logic signed [DW-1:0] dout
);
  localparam int SETTLE = sinc3_pkg::settle_ticks(OSR);
  localparam int CW     = $clog2(SETTLE + 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || (tick && clr_now))
      seen <= '0;
    else if (tick && seen < CW'(SETTLE))
      seen <= seen + 1'b1;
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dvalid |=> !dvalid);

  // R5
  settle_window_chk: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> (seen >= CW'(SETTLE)));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !dvalid);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dvalid && dout == '0));
endmodule

bind sinc3_decim sinc3_decim_chk #(.OSR(OSR), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .en(en), .tick(tick), .clr_now(clr_now),
  .dvalid(dvalid), .dout(dout)
);

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;
  localparam int OSR    = 8;
  localparam int DW     = 3 * 3 + 2;
  localparam int SETTLE = 3 * OSR + 5;
  localparam int HLEN   = 3 * OSR - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic mclk = 1'b0;
  logic mdat = 1'b0;
  logic frst = 1'b0;
  logic signed [DW-1:0] dout;
  logic dvalid;

  int total = 0;
  int bad = 0;
  int b2b = 0;
  bit prev_dv = 1'b0;
  bit done = 1'b0;

  int h [HLEN];
  int xs [256];
  int nbits = 0;
  int expv [64];
  int n_exp = 0;
  int gotv [64];
  int n_got = 0;
  logic [7:0] lfsr = 8'h5a;

  always #4 clk = ~clk;

  sinc3_decim #(.OSR(OSR), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mclk_in(mclk), .mdat_in(mdat),
    .filt_rst_in(frst), .dout(dout), .dvalid(dvalid)
  );

  always @(posedge clk) begin
    #2;
    if (dvalid) begin
      if (n_got < 64) gotv[n_got] = int'(dout);
      n_got++;
      if (prev_dv) b2b++;
    end
    prev_dv = dvalid;
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int y_of(input int n);
    int s = 0;
    for (int j = 0; j < HLEN; j++)
      if (n - 2 - j >= 1) s += h[j] * xs[n - 2 - j];
    return s;
  endfunction

  task automatic send_bit(input bit b, input bit counted);
    @(negedge clk); mclk = 1'b0; mdat = b;
    @(negedge clk);
    @(negedge clk); mclk = 1'b1;
    @(negedge clk);
    if (counted) begin
      nbits++;
      xs[nbits] = b ? 1 : -1;
      if (nbits % OSR == 0 && nbits >= SETTLE) begin
        expv[n_exp] = y_of(nbits);
        n_exp++;
      end
    end
  endtask

  task automatic check_phase(input string tag);
    chk({tag, " word count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk({tag, " word value"}, gotv[i], expv[i]);
    n_got = 0; n_exp = 0; nbits = 0;
  endtask

  // restart: pulse, one discarded bit (R6), then compare previous run
  task automatic restart(input string tag);
    @(negedge clk); frst = 1'b1;
    @(negedge clk); frst = 1'b0;
    send_bit(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check_phase(tag);
  endtask

  function automatic bit pat(input int p, input int i);
    case (p)
      0: return bit'(i % 2);
      1: return (i % 8) < 6;
      2: return ((i * 3) % 11) < 3;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    int b1 [OSR];
    int b2 [2*OSR-1];
    for (int i = 0; i < OSR; i++) b1[i] = 1;
    for (int i = 0; i < 2*OSR-1; i++) begin
      b2[i] = 0;
      for (int k = 0; k < OSR; k++)
        if (i - k >= 0 && i - k < OSR) b2[i] += b1[k];
    end
    for (int i = 0; i < HLEN; i++) begin
      h[i] = 0;
      for (int k = 0; k < 2*OSR-1; k++)
        if (i - k >= 0 && i - k < OSR) h[i] += b2[k];
    end

    repeat (4) @(negedge clk);
    // R10
    chk("R10 dvalid in reset", int'(dvalid), 0);
    chk("R10 dout in reset", int'(dout), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 dvalid after reset", int'(dvalid), 0);
    chk("R10 dout after reset", int'(dout), 0);

    // R1 all ones, R4/R5 word count
    for (int i = 0; i < 64; i++) send_bit(1'b1, 1'b1);
    for (int i = 0; i < n_exp; i++) chk("R1 model full scale", expv[i], OSR*OSR*OSR);
    restart("R1 R4 R5");

    // R2 all zeros
    for (int i = 0; i < 64; i++) send_bit(1'b0, 1'b1);
    for (int i = 0; i < n_exp; i++) chk("R2 model full scale", expv[i], -OSR*OSR*OSR);
    restart("R2 R6");

    // R3 pattern sweep
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 96; i++) begin
        bit b;
        if (p == 3) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          b = lfsr[0];
        end else b = pat(p, i);
        send_bit(b, 1'b1);
      end
      restart("R3 pattern");
    end

    // R7 restart inside the settling window
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b1);
    restart("R7 first segment");
    for (int i = 0; i < 40; i++) send_bit(pat(1, i), 1'b1);
    restart("R7 second segment");

    // R9 disable, then re-enable
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check_phase("R9 disabled");
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 40; i++) send_bit(pat(2, i), 1'b1);
    repeat (4) @(negedge clk);
    check_phase("R9 re-enabled");

    // R8
    chk("R8 back-to-back strobes", b2b, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule